// File: doc/BRIEF.md
# Clock Peripheral Interrupt Request and Poll Responder

This block is the interrupt side of a programmable interval clock on an I/O processor bus. It merges three interrupt sources into one request line. The sources are a software-settable system flag, the timer's limit-reached flag and the timer's missed-tick flag. It keeps an in-service (active) flip-flop, and it answers the processor's interrupt poll. If a request is pending, the answer is an acknowledge carrying the device number. If none is pending, the poll is passed onward so the processor cancels it.

No request flip-flop is kept. The request is computed from the flags and the enable bit on every cycle, and it is held low while the active flip-flop is set. Only a reset-interrupt strobe or a master reset clears the active flip-flop. The limit and missed-tick flags are owned and cleared by the counter logic beside this block. The system flag lives here. There is no interrupt mask.

Top module: `irq_poll_ctl`

## Requirements
- R1: `irq_req` equals NOT active AND (system flag OR (`irq_en` AND (`lim_flag` OR `lost_flag`))), evaluated combinationally from the current inputs and registered state.
- R2: A `set_int` strobe sets the system flag at the next clock edge, so `irq_req` rises in the following cycle unless active is set.
- R3: A `clr_sys` strobe clears the system flag at the next edge. If `set_int` and `clr_sys` arrive together, set wins.
- R4: A `poll_in` strobe that meets a pending request sets active. In the next cycle it produces a one-cycle `poll_ack` and drives `poll_data` with the `dev_num` sampled at the poll.
- R5: A `poll_in` strobe that meets no pending request produces a one-cycle `poll_out`, with `poll_data` zero, and leaves active unchanged.
- R6: A `rst_int` strobe clears active at the next edge. From then on, `irq_req` follows the current flags again.
- R7: When `rst_int` and `poll_in` arrive in the same cycle, active counts as cleared first. The poll is answered against the ungated request, and active ends set if it acknowledged.
- R8: A `mreset` strobe clears the system flag and active at the next edge. It overrides `set_int` and suppresses any poll response in that cycle.
- R9: `poll_ack` and `poll_out` are never high together, and `poll_data` is zero whenever neither is high.
- R10: While `rst_n` is low, and in the cycles after its synchronous release, outputs are zero and both the system flag and active are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_int | input | 1 | Strobe: set the system flag |
| clr_sys | input | 1 | Strobe: clear the system flag |
| rst_int | input | 1 | Strobe: clear the active flip-flop |
| mreset | input | 1 | Strobe: master reset of flags and active |
| irq_en | input | 1 | Enables the timer sources into the request |
| lim_flag | input | 1 | Limit-reached flag from the counter |
| lost_flag | input | 1 | Missed-tick flag from the counter |
| poll_in | input | 1 | Interrupt poll from the I/O processor |
| dev_num | input | DEV_W | Device number returned on acknowledge |
| irq_req | output | 1 | Interrupt request to the processor |
| poll_ack | output | 1 | One-cycle acknowledge of a poll |
| poll_out | output | 1 | One-cycle pass-on of a poll, telling the processor to cancel it |
| poll_data | output | DEV_W | Device number on acknowledge, otherwise zero |

## Verification
The embedded properties check several rules on every cycle. The request is never high while active is set. The acknowledge and pass-on pulses are mutually exclusive, and the data word is zero outside them. A poll that meets a request always yields an acknowledge with the sampled device number on the next cycle. A set, reset-interrupt or master reset strobe moves its flag at the next edge. Other behaviour can only be shown by the bench's sequences. These include the exact request formula over enable and flag combinations, the way active gates a system request raised while in service, the same-cycle reset-and-poll ordering, master reset overriding set and poll, and the state after an asynchronous reset in mid-operation.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  // Kind of answer given to an interrupt poll
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_ACK  = 2'd1,
    RSP_PASS = 2'd2
  } poll_rsp_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_int,
  input  logic clr_sys,
  input  logic mreset,
  output logic sys_flag
);
  logic sys_d, sys_q, sys_en;

  always_comb begin
    sys_en = mreset | set_int | clr_sys;
    if (mreset)       sys_d = 1'b0;
    else if (set_int) sys_d = 1'b1;
    else              sys_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sys_q <= 1'b0;
    else if (sys_en) sys_q <= sys_d;
  end

  assign sys_flag = sys_q;

  // R2
  set_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_int && !mreset) |=> sys_flag);
  // R8
  mreset_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> !sys_flag);
endmodule

// File: rtl/irq_active_trk.sv
module irq_active_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic mreset,
  input  logic rst_int,
  input  logic poll_hit,
  input  logic raw_req,
  output logic active,
  output logic irq_req
);
  logic act_d, act_q, act_en;

  always_comb begin
    act_en = mreset | rst_int | poll_hit;
    if (mreset)        act_d = 1'b0;
    else if (poll_hit) act_d = 1'b1;
    else               act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  assign active  = act_q;
  assign irq_req = raw_req & ~act_q;

  // R1
  no_req_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !irq_req);
  // R6
  rst_int_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_int && !poll_hit) |=> !active);
  // R8
  mreset_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> !active);
endmodule

// File: rtl/irq_poll_resp.sv
module irq_poll_resp
  import irq_poll_pkg::*;
#(
  parameter int DEV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_in,
  input  logic             mreset,
  input  logic             rst_int,
  input  logic             active,
  input  logic             raw_req,
  input  logic [DEV_W-1:0] dev_num,
  output logic             poll_hit,
  output logic             poll_ack,
  output logic             poll_out,
  output logic [DEV_W-1:0] poll_data
);
  poll_rsp_e        rsp_d, rsp_q;
  logic [DEV_W-1:0] data_d, data_q;
  logic             pend;

  always_comb begin
    // a reset-interrupt in the same cycle is taken before the poll
    pend     = raw_req & (~active | rst_int);
    poll_hit = poll_in & pend & ~mreset;
    rsp_d    = RSP_IDLE;
    data_d   = '0;
    if (poll_in && !mreset) begin
      if (pend) begin
        rsp_d  = RSP_ACK;
        data_d = dev_num;
      end else begin
        rsp_d  = RSP_PASS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q  <= RSP_IDLE;
      data_q <= '0;
    end else begin
      rsp_q  <= rsp_d;
      data_q <= data_d;
    end
  end

  assign poll_ack  = (rsp_q == RSP_ACK);
  assign poll_out  = (rsp_q == RSP_PASS);
  assign poll_data = data_q;

  // R9
  ack_pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({poll_ack, poll_out}) <= 1);
  // R9
  data_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_ack && !poll_out) |-> (poll_data == '0));
  // R4
  ack_carries_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_in && !mreset && raw_req && !active) |=> (poll_ack && poll_data == $past(dev_num)));
  // R5
  pass_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_in && !mreset && !raw_req) |=> (poll_out && !poll_ack));
endmodule

// File: rtl/irq_poll_ctl.sv
module irq_poll_ctl #(
  parameter int DEV_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_int,
  input  logic             clr_sys,
  input  logic             rst_int,
  input  logic             mreset,
  input  logic             irq_en,
  input  logic             lim_flag,
  input  logic             lost_flag,
  input  logic             poll_in,
  input  logic [DEV_W-1:0] dev_num,
  output logic             irq_req,
  output logic             poll_ack,
  output logic             poll_out,
  output logic [DEV_W-1:0] poll_data
);
  logic rst_sync_n;
  logic sys_flag;
  logic raw_req;
  logic active;
  logic poll_hit;

  irq_rst_sync #(.STAGES(SYNC_STGS)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_src_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set_int(set_int),
    .clr_sys(clr_sys), .mreset(mreset), .sys_flag(sys_flag)
  );

  // ungated request: system flag or enabled timer sources
  assign raw_req = sys_flag | (irq_en & (lim_flag | lost_flag));

  irq_active_trk u_act (
    .clk(clk), .rst_n(rst_sync_n), .mreset(mreset), .rst_int(rst_int),
    .poll_hit(poll_hit), .raw_req(raw_req), .active(active), .irq_req(irq_req)
  );

  irq_poll_resp #(.DEV_W(DEV_W)) u_poll (
    .clk(clk), .rst_n(rst_sync_n), .poll_in(poll_in), .mreset(mreset),
    .rst_int(rst_int), .active(active), .raw_req(raw_req), .dev_num(dev_num),
    .poll_hit(poll_hit), .poll_ack(poll_ack), .poll_out(poll_out),
    .poll_data(poll_data)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_sync_n) |-> (!poll_ack && !poll_out && poll_data == '0));
endmodule

// File: tb/irq_poll_ctl_tb.sv
module irq_poll_ctl_tb_top;
  localparam int DW  = 8;
  localparam int NV  = 18;
  localparam logic [DW-1:0] DEV = 8'h2A;

  logic clk = 1'b0;
  logic rst_n;
  logic set_int, clr_sys, rst_int, mreset, irq_en, lim_flag, lost_flag, poll_in;
  logic [DW-1:0] dev_num;
  logic irq_req, poll_ack, poll_out;
  logic [DW-1:0] poll_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_poll_ctl #(.DEV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_int(set_int), .clr_sys(clr_sys),
    .rst_int(rst_int), .mreset(mreset), .irq_en(irq_en), .lim_flag(lim_flag),
    .lost_flag(lost_flag), .poll_in(poll_in), .dev_num(dev_num),
    .irq_req(irq_req), .poll_ack(poll_ack), .poll_out(poll_out),
    .poll_data(poll_data)
  );

  // {set,rst_int,poll,mreset,clr_sys,en,lim,lost} {req,ack,pass} data
  localparam logic [18:0] VEC [NV] = '{
    {8'b0000_0010, 3'b000, 8'h00},  // R1 enable off masks limit
    {8'b0000_0110, 3'b100, 8'h00},  // R1 enabled limit requests
    {8'b0010_0110, 3'b010, DEV  },  // R4 poll acknowledged
    {8'b0000_0110, 3'b000, 8'h00},  // R4 R1 active gates request
    {8'b1000_0110, 3'b000, 8'h00},  // R2 set while active stays gated
    {8'b0010_0110, 3'b001, 8'h00},  // R5 poll while active passes on
    {8'b0100_0000, 3'b100, 8'h00},  // R6 release shows system flag
    {8'b0000_1000, 3'b000, 8'h00},  // R3 clear system flag
    {8'b0000_0101, 3'b100, 8'h00},  // R1 lost-tick source
    {8'b0000_0001, 3'b000, 8'h00},  // R1 lost-tick with enable off
    {8'b0010_0000, 3'b001, 8'h00},  // R5 empty poll
    {8'b1000_0000, 3'b100, 8'h00},  // R2 set raises request
    {8'b0010_0000, 3'b010, DEV  },  // R4 acknowledge of system source
    {8'b0110_0000, 3'b010, DEV  },  // R7 reset and poll together
    {8'b0001_0000, 3'b000, 8'h00},  // R8 master reset
    {8'b0000_0110, 3'b100, 8'h00},  // R8 active cleared by master reset
    {8'b1001_0000, 3'b000, 8'h00},  // R8 master reset beats set
    {8'b0011_0110, 3'b100, 8'h00}   // R8 master reset suppresses poll
  };

  task automatic put(input logic [7:0] v);
    {set_int, rst_int, poll_in, mreset, clr_sys, irq_en, lim_flag, lost_flag} = v;
  endtask

  task automatic check(input string tag, input logic [2:0] exp_f, input logic [DW-1:0] exp_d);
    checks++;
    if ({irq_req, poll_ack, poll_out} !== exp_f || poll_data !== exp_d) begin
      fails++;
      $display("FAIL %s: got req/ack/pass=%b data=%h, expected %b data=%h",
               tag, {irq_req, poll_ack, poll_out}, poll_data, exp_f, exp_d);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    dev_num = DEV;
    put(8'h00);
    repeat (3) @(posedge clk);
    #1 check("R10 in reset", 3'b000, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 after release", 3'b000, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) put(VEC[i][18:11]);
      @(posedge clk) #1;
      check($sformatf("vector %0d", i), VEC[i][10:8], VEC[i][7:0]);
    end

    // R9 R4 pulse lasts one cycle
    @(negedge clk) put(8'b0000_0110);
    @(negedge clk) put(8'b0010_0110); dev_num = 8'h11;
    @(negedge clk) put(8'b0000_0110); dev_num = 8'h77;
    #1 check("R4 sampled device number", 3'b010, 8'h11);
    @(posedge clk) #1 check("R9 pulse ends", 3'b000, 8'h00);

    // R10 asynchronous reset in mid-service
    @(negedge clk) put(8'b1000_0000);
    @(negedge clk) put(8'h00); rst_n = 1'b0;
    #1 check("R10 async clear", 3'b000, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 state cleared", 3'b000, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule